// File: doc/BRIEF.md
# Lockable Boot-Loaded Configuration Register

This block holds one 32-bit configuration word that drives the timer and clock blocks of the chip. During the pre-boot phase a single-cycle strobe presents the word read from nonvolatile configuration storage. The register accepts that word only when the read is trusted: no fail status and no blank (erased) indication. If either flag is set, the register keeps its reset value.

After the pre-boot load, software can update the register through a single-cycle write port with byte enables. A 2-bit lock code sets which fields may change. With code `00` every implemented bit is writable. With code `10` only the two-bit watchdog run-clock select field at bits 11:10 is writable. With codes `01` and `11` nothing is writable. Bit 6 is not implemented. A write that would touch a bit the lock code forbids leaves that bit unchanged and sets a sticky error flag.

Top module: `cfg_lock_reg`

## Requirements
- R1: After reset the register reads 0x7F7F_FF38 and `wrError` is 0.
- R2: On the first `bootLoad` cycle after reset with `bootFail`=0 and `bootBlank`=0, `cfgValue` equals `bootWord` with bit 6 cleared from the next clock edge on.
- R3: On the first `bootLoad` cycle with `bootFail`=1 or `bootBlank`=1, the flash word is discarded and `cfgValue` keeps its value.
- R4: Only the first `bootLoad` cycle after reset is acted on. Later strobes leave `cfgValue` unchanged, whatever they carry.
- R5: A bus write in the same cycle as the first `bootLoad` is discarded and raises no error. The load result alone decides the value.
- R6: With `lockCode`=00, a write replaces every implemented bit in each byte whose `wrByteEn` bit is 1 (bit i enables bits 8i+7:8i). Bytes whose enable is 0 are unchanged.
- R7: With `lockCode`=10, a write changes only bits 11:10 (when byte 1 is enabled). All other bits are unchanged.
- R8: With `lockCode`=01 or 11, a write changes no bit.
- R9: Bit 6 of `cfgValue` always reads 0, whatever is loaded or written.
- R10: `wrError` is set by a write, not in a load cycle, whose enabled bytes contain an implemented bit the lock code forbids. It then stays 1 until reset. Permitted writes never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bootLoad | input | 1 | Single-cycle pre-boot load strobe |
| bootWord | input | 32 | Configuration word from nonvolatile storage |
| bootFail | input | 1 | Read of the word reported a failure |
| bootBlank | input | 1 | Word reads as blank/erased |
| lockCode | input | 2 | Lock level: 00 open, 10 clock-select only, 01/11 locked |
| wrEn | input | 1 | Single-cycle bus write strobe |
| wrData | input | 32 | Bus write data |
| wrByteEn | input | 4 | Byte enables for the write |
| cfgValue | output | 32 | Current register value |
| wrError | output | 1 | Sticky flag: a forbidden write was attempted |

## Verification
The assertions assume that `bootLoad`, `wrEn`, `lockCode` and the data inputs are stable around each rising edge. They also assume that `lockCode` describes the cycle in which the write is sampled. The bench drives every input on the falling edge and holds it through the following rising edge, so both assumptions are met. It clears `wrEn` and `bootLoad` after one cycle, which keeps the strobes single-cycle as the block expects. The lock sweep covers all four codes against all sixteen byte-enable patterns, with data that differs for each write, so that every field boundary is exercised.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int CFG_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = CFG_W / BYTE_W;
  localparam int LOCK_W    = 2;

  localparam logic [CFG_W-1:0] RESET_VAL   = 32'h7F7F_FF38;
  localparam logic [CFG_W-1:0] IMPL_MASK   = 32'hFFFF_FFBF;
  localparam logic [CFG_W-1:0] CLKSEL_MASK = 32'h0000_0C00;

  localparam logic [LOCK_W-1:0] LOCK_OPEN   = 2'b00;
  localparam logic [LOCK_W-1:0] LOCK_CLKSEL = 2'b10;

  typedef struct packed {
    logic             loadTake;
    logic [CFG_W-1:0] wrMask;
  } strobe_t;
endpackage

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bootLoad,
  input  logic                 bootFail,
  input  logic                 bootBlank,
  input  logic [LOCK_W-1:0]    lockCode,
  input  logic                 wrEn,
  input  logic [NUM_BYTES-1:0] wrByteEn,
  output strobe_t              strb,
  output logic                 wrError
);
  logic             loadDone;
  logic             firstLoad;
  logic             busActive;
  logic             denied;
  logic [CFG_W-1:0] byteMask;
  logic [CFG_W-1:0] allowMask;

  assign firstLoad = bootLoad && !loadDone;
  assign busActive = wrEn && !firstLoad;

  // Expand byte enables to a bit mask
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byteMask
    assign byteMask[b*BYTE_W +: BYTE_W] = {BYTE_W{wrByteEn[b]}};
  end

  always_comb begin
    unique case (lockCode)
      LOCK_OPEN:   allowMask = IMPL_MASK;
      LOCK_CLKSEL: allowMask = CLKSEL_MASK;
      default:     allowMask = '0;
    endcase
  end

  assign denied        = busActive && |(byteMask & IMPL_MASK & ~allowMask);
  assign strb.loadTake = firstLoad && !bootFail && !bootBlank;
  assign strb.wrMask   = busActive ? (byteMask & allowMask) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadDone <= 1'b0;
      wrError  <= 1'b0;
    end else begin
      if (bootLoad) loadDone <= 1'b1;
      if (denied)   wrError  <= 1'b1;
    end
  end

  // R4: once a load strobe has been seen, no further load is taken
  assert_load_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    bootLoad |=> !strb.loadTake);

  // R5: the load cycle carries no write strobe and raises no error
  assert_load_blocks_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bootLoad && !loadDone && !wrError) |=> !wrError);

  // R10: the error flag is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrError |=> wrError);

  // R8: fully locked codes never produce a write mask
  assert_locked_nowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    lockCode[0] |-> (strb.wrMask == '0));
endmodule

// File: rtl/cfg_lock_data.sv
module cfg_lock_data
  import cfg_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CFG_W-1:0] bootWord,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] cfgValue
);
  logic [CFG_W-1:0] regQ;
  logic [CFG_W-1:0] regD;

  always_comb begin
    if (strb.loadTake) regD = bootWord;
    else               regD = (regQ & ~strb.wrMask) | (wrData & strb.wrMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= RESET_VAL;
    else       regQ <= regD & IMPL_MASK;
  end

  assign cfgValue = regQ;

  // R9: unimplemented bits stay zero
  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regQ & ~IMPL_MASK) == '0);

  // R2: a taken load lands the word in the next cycle
  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTake |=> regQ == ($past(bootWord) & IMPL_MASK));

  // R3: without a load or write strobe the register holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadTake && strb.wrMask == '0) |=> $stable(regQ));
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg
  import cfg_lock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bootLoad,
  input  logic [CFG_W-1:0]     bootWord,
  input  logic                 bootFail,
  input  logic                 bootBlank,
  input  logic [LOCK_W-1:0]    lockCode,
  input  logic                 wrEn,
  input  logic [CFG_W-1:0]     wrData,
  input  logic [NUM_BYTES-1:0] wrByteEn,
  output logic [CFG_W-1:0]     cfgValue,
  output logic                 wrError
);
  strobe_t strb;

  cfg_lock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bootLoad(bootLoad), .bootFail(bootFail),
    .bootBlank(bootBlank), .lockCode(lockCode), .wrEn(wrEn),
    .wrByteEn(wrByteEn), .strb(strb), .wrError(wrError)
  );

  cfg_lock_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .bootWord(bootWord),
    .wrData(wrData), .cfgValue(cfgValue)
  );

  // R7: under the clock-select lock only bits 11:10 can move
  assert_clksel_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lockCode == LOCK_CLKSEL && !bootLoad) |=>
      ((cfgValue ^ $past(cfgValue)) & ~CLKSEL_MASK) == '0);
endmodule

// File: tb/tb_cfg_lock_reg.sv
`timescale 1ns/1ps
module tb_cfg_lock_reg;
  localparam logic [31:0] RST_V  = 32'h7F7F_FF38;
  localparam logic [31:0] IMPL_V = 32'hFFFF_FFBF;
  localparam logic [31:0] CKS_V  = 32'h0000_0C00;

  logic        clk = 1'b0;
  logic        rstN;
  logic        bootLoad, bootFail, bootBlank, wrEn;
  logic [31:0] bootWord, wrData;
  logic [1:0]  lockCode;
  logic [3:0]  wrByteEn;
  logic [31:0] cfgValue;
  logic        wrError;

  int checks = 0;
  int errors = 0;
  logic [31:0] expVal;
  logic        expErr;

  always #2.5 clk = ~clk;

  cfg_lock_reg dut (
    .clk(clk), .rstN(rstN), .bootLoad(bootLoad), .bootWord(bootWord),
    .bootFail(bootFail), .bootBlank(bootBlank), .lockCode(lockCode),
    .wrEn(wrEn), .wrData(wrData), .wrByteEn(wrByteEn),
    .cfgValue(cfgValue), .wrError(wrError)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] allowOf(input logic [1:0] lc);
    if (lc == 2'b00)      return IMPL_V;
    else if (lc == 2'b10) return CKS_V;
    else                  return 32'h0;
  endfunction

  function automatic logic [31:0] maskOf(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; bootLoad = 0; bootFail = 0; bootBlank = 0; wrEn = 0;
    bootWord = '0; wrData = '0; lockCode = 2'b00; wrByteEn = '0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expVal = RST_V; expErr = 1'b0;
  endtask

  task automatic doLoad(input logic [31:0] w, input logic f, input logic b, input logic withWr);
    bootLoad = 1; bootWord = w; bootFail = f; bootBlank = b;
    wrEn = withWr; wrData = 32'h0; wrByteEn = 4'hF; lockCode = 2'b00;
    @(negedge clk);
    bootLoad = 0; wrEn = 0; bootFail = 0; bootBlank = 0;
  endtask

  task automatic doWrite(input logic [1:0] lc, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] bm, am;
    bm = maskOf(be); am = allowOf(lc);
    lockCode = lc; wrByteEn = be; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    expVal = (expVal & ~(bm & am)) | (d & bm & am);
    if ((bm & IMPL_V & ~am) != 0) expErr = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    doReset();
    check("R1 reset value", cfgValue, RST_V);
    check("R1 reset error flag", {31'b0, wrError}, 32'h0);

    // trusted load
    doLoad(32'h1234_56C7, 0, 0, 0);
    check("R2 trusted load", cfgValue, 32'h1234_5687);
    check("R9 bit6 after load", cfgValue & 32'h40, 32'h0);
    doLoad(32'hFFFF_FFFF, 0, 0, 0);
    check("R4 second strobe ignored", cfgValue, 32'h1234_5687);

    // failed load, then a later trusted strobe is also ignored
    doReset();
    doLoad(32'h0000_0000, 1, 0, 0);
    check("R3 fail keeps reset", cfgValue, RST_V);
    doLoad(32'h0000_1111, 0, 0, 0);
    check("R4 strobe after failed load ignored", cfgValue, RST_V);

    // blank load
    doReset();
    doLoad(32'hAAAA_0000, 0, 1, 0);
    check("R3 blank keeps reset", cfgValue, RST_V);

    // load with simultaneous write
    doReset();
    doLoad(32'hC3C3_C3C3, 0, 0, 1);
    check("R5 load wins over write", cfgValue, 32'hC3C3_C383);
    check("R5 no error in load cycle", {31'b0, wrError}, 32'h0);
    expVal = 32'hC3C3_C383;

    // permitted writes never raise the error
    doWrite(2'b00, 4'hF, 32'hFFFF_FFFF);
    check("R6 full write lock00", cfgValue, expVal);
    check("R9 bit6 after write", cfgValue & 32'h40, 32'h0);
    check("R10 no error for permitted write", {31'b0, wrError}, 32'h0);
    doWrite(2'b10, 4'h0, 32'h0);
    check("R10 no error with no bytes", {31'b0, wrError}, 32'h0);

    // sweep: every lock code against every byte-enable pattern
    for (int lc = 0; lc < 4; lc++) begin
      for (int be = 0; be < 16; be++) begin
        logic [31:0] d;
        d = {4{8'(lc * 16 + be)}} ^ 32'h5AC3_3CA5 ^ {be[3:0], 28'h0} ^ {28'h0, lc[1:0], 2'b0};
        doWrite(2'(lc), 4'(be), d);
        if (lc == 0)      check("R6 lock00 sweep", cfgValue, expVal);
        else if (lc == 2) check("R7 lock10 sweep", cfgValue, expVal);
        else              check("R8 locked sweep", cfgValue, expVal);
        check("R9 bit6 sweep", cfgValue & 32'h40, 32'h0);
        check("R10 error flag sweep", {31'b0, wrError}, {31'b0, expErr});
      end
      // restore a varied value under the open lock for the next code
      doWrite(2'b00, 4'hF, 32'h9669_A55A ^ {30'h0, lc[1:0]});
      check("R6 reseed", cfgValue, expVal);
    end

    // error clears only by reset
    doReset();
    check("R10 error cleared by reset", {31'b0, wrError}, 32'h0);
    doWrite(2'b11, 4'h1, 32'h0);
    check("R8 lock11 write ignored", cfgValue, RST_V);
    check("R10 error raised", {31'b0, wrError}, 32'h1);
    doWrite(2'b00, 4'h1, 32'h0);
    check("R10 error sticky", {31'b0, wrError}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule